// File: doc/BRIEF.md
# Receive Byte Match Detector

This unit sits beside a receive data path and watches every byte as it is handed on toward memory. It holds a parameterised set of candidate byte values, each with an enable bit, and flags a hit for every enabled candidate that equals the byte in flight. A hit latches the receive and transmit transfer counts of that cycle, so software can later tell exactly where in a stream a delimiter appeared. It also sets a sticky event flag for the candidate. The event flags, gated by per-candidate interrupt enables, form one interrupt request.

Each candidate can be made single-use: its enable drops on its own hit. Two shortcut options let a hit re-arm the same candidate or arm the next one, counting modulo the candidate count. Enabling candidates in a ring this way detects multi-byte delimiters one byte at a time. Software sets the enable bits as a group through a configuration write, and per-candidate task pulses set or clear single bits.

Top module: `rxm_match_unit`

## Requirements
- R1: A candidate hits in a cycle when `byte_vld` is high, its enable bit as held at that clock edge is 1, and `byte_dat` equals its value (candidate i is `cand_val[i*DW +: DW]`). A disabled candidate or a cycle with `byte_vld` low produces no hit.
- R2: When any candidate hits, `rx_amount` and `tx_amount` take the values of `rx_count` and `tx_count` from the hit cycle at that clock edge. With no hit they hold their value.
- R3: A hit on candidate i with `oneshot_cfg[i]` set clears enable bit i.
- R4: A hit on candidate i sets enable bit (i+1) mod NCAND when `chain_cfg[i]` is set, and sets enable bit i when `rearm_cfg[i]` is set. A re-arm overrides the one-shot clear of the same hit.
- R5: `task_en[i]` sets enable bit i and `task_dis[i]` clears it. When a disable pulse lands in the same cycle as any enable source for that bit (configuration write, enable task or shortcut), the disable wins.
- R6: A hit sets event flag i, and the flag stays set until an `evt_clr[i]` pulse, which stands for a software write of zero. When a hit and a clear land on the same flag in one cycle, the hit wins.
- R7: `irq` is high exactly when some flag `evt_flag[i]` and `irq_en[i]` are both 1. In the default variant it follows these inputs in the same cycle.
- R8: `en_wr` loads all enable bits from `en_wdata`. Task pulses are applied on top of that value, and hit results (one-shot clear, shortcut sets) are applied after the tasks.
- R9: After reset all enable bits, event flags, captured counts and `irq` are 0.
- R10: Several candidates may hit in the same cycle. All of their flags are set, and the counts are captured once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | Received byte is being moved this cycle |
| byte_dat | input | DW | Received byte value |
| rx_count | input | CW | Current receive transfer count |
| tx_count | input | CW | Current transmit transfer count |
| cand_val | input | NCAND*DW | Candidate values, candidate i in bits i*DW +: DW |
| oneshot_cfg | input | NCAND | Disable candidate on its own hit |
| chain_cfg | input | NCAND | Hit on i enables candidate (i+1) mod NCAND |
| rearm_cfg | input | NCAND | Hit on i re-enables candidate i |
| en_wr | input | 1 | Configuration write of the enable bits |
| en_wdata | input | NCAND | Enable bits to load |
| task_en | input | NCAND | Per-candidate enable pulse |
| task_dis | input | NCAND | Per-candidate disable pulse |
| evt_clr | input | NCAND | Per-flag clear pulse (write of zero) |
| irq_en | input | NCAND | Interrupt enable per event flag |
| match_en | output | NCAND | Current enable bits |
| evt_flag | output | NCAND | Sticky match event flags |
| rx_amount | output | CW | Receive count captured at the last hit |
| tx_amount | output | CW | Transmit count captured at the last hit |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A disable pulse always leaves its enable bit clear, and a hit always sets its flag. A one-shot hit with no re-arm or chain back into it leaves the candidate off. The captured counts only move on a hit, and they then equal the counts of the hit cycle. A flag changes only through a hit or a clear, and a rising interrupt always has an enabled flag behind it. The ordering questions can only be shown by the bench's sequences. These are: a task and a hit on the same bit in one cycle, a chain that wraps from the last candidate to the first, a re-arm overriding a one-shot, simultaneous hits on duplicate values, and a hit that is judged against the enable state held before that cycle's tasks.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
   // Index of the candidate armed by a chain shortcut from candidate idx
   function automatic int unsigned ring_next(input int unsigned idx, input int unsigned n);
      return (idx + 1) % n;
   endfunction

   // Index of the candidate whose chain shortcut arms candidate idx
   function automatic int unsigned ring_prev(input int unsigned idx, input int unsigned n);
      return (idx + n - 1) % n;
   endfunction
endpackage

// File: rtl/rxm_cmp_bank.sv
module rxm_cmp_bank #(
   parameter int unsigned NCAND = 4,
   parameter int unsigned DW    = 8
) (
   input  logic                  byte_vld,
   input  logic [DW-1:0]         byte_dat,
   input  logic [NCAND*DW-1:0]   cand_val,
   input  logic [NCAND-1:0]      en_q,
   output logic [NCAND-1:0]      hit
);
   // one comparator per candidate, all in parallel
   for (genvar g = 0; g < NCAND; g++) begin : g_cmp
      logic [DW-1:0] ref_val;
      assign ref_val = cand_val[g*DW +: DW];
      assign hit[g]  = byte_vld & en_q[g] & (byte_dat == ref_val);
   end
endmodule

// File: rtl/rxm_enable_ctl.sv
module rxm_enable_ctl #(
   parameter int unsigned NCAND = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic [NCAND-1:0]  en_wdata,
   input  logic [NCAND-1:0]  task_en,
   input  logic [NCAND-1:0]  task_dis,
   input  logic [NCAND-1:0]  hit,
   input  logic [NCAND-1:0]  oneshot_cfg,
   input  logic [NCAND-1:0]  chain_cfg,
   input  logic [NCAND-1:0]  rearm_cfg,
   output logic [NCAND-1:0]  en_q
);
   import rxm_pkg::*;

   logic [NCAND-1:0] after_task;
   logic [NCAND-1:0] hit_clr;
   logic [NCAND-1:0] hit_set;
   logic [NCAND-1:0] en_nxt;

   // stage 1: software write, then enable tasks on top
   always_comb begin
      after_task = en_wr ? en_wdata : en_q;
      after_task = after_task | task_en;
   end

   // stage 2: hit consequences, computed per candidate
   for (genvar g = 0; g < NCAND; g++) begin : g_hit
      localparam int unsigned PREV = ring_prev(g, NCAND);
      assign hit_clr[g] = hit[g] & oneshot_cfg[g];
      assign hit_set[g] = (hit[g] & rearm_cfg[g]) | (hit[PREV] & chain_cfg[PREV]);
   end

   // stage 3: explicit disable overrides every set source
   always_comb begin
      en_nxt = ((after_task & ~hit_clr) | hit_set) & ~task_dis;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_nxt;
   end
endmodule

// File: rtl/rxm_event_cap.sv
module rxm_event_cap #(
   parameter int unsigned NCAND   = 4,
   parameter int unsigned CW      = 16,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCAND-1:0]  hit,
   input  logic [NCAND-1:0]  evt_clr,
   input  logic [NCAND-1:0]  irq_en,
   input  logic [CW-1:0]     rx_count,
   input  logic [CW-1:0]     tx_count,
   output logic [NCAND-1:0]  evt_q,
   output logic [CW-1:0]     rx_amt_q,
   output logic [CW-1:0]     tx_amt_q,
   output logic              irq
);
   logic             any_hit;
   logic [NCAND-1:0] evt_nxt;

   assign any_hit = |hit;
   // a hit outranks a clear arriving in the same cycle
   assign evt_nxt = (evt_q & ~evt_clr) | hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q    <= '0;
         rx_amt_q <= '0;
         tx_amt_q <= '0;
      end else begin
         evt_q <= evt_nxt;
         if (any_hit) begin
            rx_amt_q <= rx_count;
            tx_amt_q <= tx_count;
         end
      end
   end

   if (REG_IRQ) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(evt_nxt & irq_en);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(evt_q & irq_en);
   end
endmodule

// File: rtl/rxm_match_unit.sv
module rxm_match_unit #(
   parameter int unsigned NCAND   = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned CW      = 16,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic [DW-1:0]         byte_dat,
   input  logic [CW-1:0]         rx_count,
   input  logic [CW-1:0]         tx_count,
   input  logic [NCAND*DW-1:0]   cand_val,
   input  logic [NCAND-1:0]      oneshot_cfg,
   input  logic [NCAND-1:0]      chain_cfg,
   input  logic [NCAND-1:0]      rearm_cfg,
   input  logic                  en_wr,
   input  logic [NCAND-1:0]      en_wdata,
   input  logic [NCAND-1:0]      task_en,
   input  logic [NCAND-1:0]      task_dis,
   input  logic [NCAND-1:0]      evt_clr,
   input  logic [NCAND-1:0]      irq_en,
   output logic [NCAND-1:0]      match_en,
   output logic [NCAND-1:0]      evt_flag,
   output logic [CW-1:0]         rx_amount,
   output logic [CW-1:0]         tx_amount,
   output logic                  irq
);
   // elaboration-time parameter checks
   if (NCAND < 1 || NCAND > 32) begin : g_bad_ncand
      $error("rxm_match_unit: NCAND must lie in 1..32");
   end
   if (DW < 1 || DW > 16) begin : g_bad_dw
      $error("rxm_match_unit: DW must lie in 1..16");
   end
   if (CW < 1) begin : g_bad_cw
      $error("rxm_match_unit: CW must be at least 1");
   end

   logic [NCAND-1:0] hit;
   logic [NCAND-1:0] en_q;

   rxm_cmp_bank #(.NCAND(NCAND), .DW(DW)) u_cmp (
      .byte_vld (byte_vld),
      .byte_dat (byte_dat),
      .cand_val (cand_val),
      .en_q     (en_q),
      .hit      (hit)
   );

   rxm_enable_ctl #(.NCAND(NCAND)) u_en (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_wr       (en_wr),
      .en_wdata    (en_wdata),
      .task_en     (task_en),
      .task_dis    (task_dis),
      .hit         (hit),
      .oneshot_cfg (oneshot_cfg),
      .chain_cfg   (chain_cfg),
      .rearm_cfg   (rearm_cfg),
      .en_q        (en_q)
   );

   rxm_event_cap #(.NCAND(NCAND), .CW(CW), .REG_IRQ(REG_IRQ)) u_evt (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit),
      .evt_clr  (evt_clr),
      .irq_en   (irq_en),
      .rx_count (rx_count),
      .tx_count (tx_count),
      .evt_q    (evt_flag),
      .rx_amt_q (rx_amount),
      .tx_amt_q (tx_amount),
      .irq      (irq)
   );

   assign match_en = en_q;
endmodule

// File: rtl/rxm_match_chk.sv
module rxm_match_chk #(
   parameter int unsigned NCAND   = 4,
   parameter int unsigned DW      = 8,
   parameter int unsigned CW      = 16,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  byte_vld,
   input  logic [DW-1:0]         byte_dat,
   input  logic [CW-1:0]         rx_count,
   input  logic [CW-1:0]         tx_count,
   input  logic [NCAND*DW-1:0]   cand_val,
   input  logic [NCAND-1:0]      oneshot_cfg,
   input  logic [NCAND-1:0]      chain_cfg,
   input  logic [NCAND-1:0]      rearm_cfg,
   input  logic [NCAND-1:0]      task_dis,
   input  logic [NCAND-1:0]      evt_clr,
   input  logic [NCAND-1:0]      irq_en,
   input  logic [NCAND-1:0]      match_en,
   input  logic [NCAND-1:0]      evt_flag,
   input  logic [CW-1:0]         rx_amount,
   input  logic [CW-1:0]         tx_amount,
   input  logic                  irq
);
   import rxm_pkg::*;

   logic [NCAND-1:0] seen;
   for (genvar g = 0; g < NCAND; g++) begin : g_seen
      assign seen[g] = byte_vld && match_en[g] && (byte_dat == cand_val[g*DW +: DW]);
   end

   for (genvar g = 0; g < NCAND; g++) begin : g_prop
      localparam int unsigned PREV = ring_prev(g, NCAND);

      p_dis_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         task_dis[g] |=> !match_en[g]);

      p_evt_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
         seen[g] |=> evt_flag[g]);

      p_evt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (!seen[g] && !evt_clr[g]) |=> $stable(evt_flag[g]));

      p_oneshot_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (seen[g] && oneshot_cfg[g] && !rearm_cfg[g] && !(seen[PREV] && chain_cfg[PREV]))
         |=> !match_en[g]);
   end

   p_amt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen == '0) |=> ($stable(rx_amount) && $stable(tx_amount)));

   p_amt_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen != '0) |=> (rx_amount == $past(rx_count) && tx_amount == $past(tx_count)));

   if (!REG_IRQ) begin : g_irq_chk
      p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq) |-> ((evt_flag & irq_en) != '0));
   end
endmodule

bind rxm_match_unit rxm_match_chk #(
   .NCAND(NCAND), .DW(DW), .CW(CW), .REG_IRQ(REG_IRQ)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .byte_vld    (byte_vld),
   .byte_dat    (byte_dat),
   .rx_count    (rx_count),
   .tx_count    (tx_count),
   .cand_val    (cand_val),
   .oneshot_cfg (oneshot_cfg),
   .chain_cfg   (chain_cfg),
   .rearm_cfg   (rearm_cfg),
   .task_dis    (task_dis),
   .evt_clr     (evt_clr),
   .irq_en      (irq_en),
   .match_en    (match_en),
   .evt_flag    (evt_flag),
   .rx_amount   (rx_amount),
   .tx_amount   (tx_amount),
   .irq         (irq)
);

// File: tb/test_rxm_match_unit.sv
module test_rxm_match_unit;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 4;
   localparam int DW = 8;
   localparam int CW = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              byte_vld = 1'b0;
   logic [DW-1:0]     byte_dat = '0;
   logic [CW-1:0]     rx_count = '0;
   logic [CW-1:0]     tx_count = '0;
   logic [NC*DW-1:0]  cand_val = {8'h44, 8'h33, 8'h22, 8'h11};
   logic [NC-1:0]     oneshot_cfg = 4'b0001;
   logic [NC-1:0]     chain_cfg = 4'b0010;
   logic [NC-1:0]     rearm_cfg = 4'b0000;
   logic              en_wr = 1'b0;
   logic [NC-1:0]     en_wdata = '0;
   logic [NC-1:0]     task_en = '0;
   logic [NC-1:0]     task_dis = '0;
   logic [NC-1:0]     evt_clr = '0;
   logic [NC-1:0]     irq_en = '0;
   logic [NC-1:0]     match_en;
   logic [NC-1:0]     evt_flag;
   logic [CW-1:0]     rx_amount;
   logic [CW-1:0]     tx_amount;
   logic              irq;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;
   logic [CW-1:0] exp_rx = '0;
   logic [CW-1:0] exp_tx = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxm_match_unit #(.NCAND(NC), .DW(DW), .CW(CW)) i_rxm_match_unit (
      .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
      .rx_count(rx_count), .tx_count(tx_count), .cand_val(cand_val),
      .oneshot_cfg(oneshot_cfg), .chain_cfg(chain_cfg), .rearm_cfg(rearm_cfg),
      .en_wr(en_wr), .en_wdata(en_wdata), .task_en(task_en), .task_dis(task_dis),
      .evt_clr(evt_clr), .irq_en(irq_en), .match_en(match_en), .evt_flag(evt_flag),
      .rx_amount(rx_amount), .tx_amount(tx_amount), .irq(irq)
   );

   // row: wr | wdata | ten | tdis | clr | vld | byte | hit | exp_en | exp_evt
   // candidates 0..3 = 11,22,33,44; one-shot on 0; chain from 1 to 2
   localparam int NROW = 13;
   localparam logic [34:0] TBL [NROW] = '{
      {1'b1,4'b0011,4'b0000,4'b0000,4'b0000,1'b1,8'h11,1'b0,4'b0011,4'b0000}, // R8 hit judged on old enables
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,8'h11,1'b1,4'b0010,4'b0001}, // R1 R3 one-shot hit
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,8'h11,1'b0,4'b0010,4'b0001}, // R1 disabled candidate
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,8'h22,1'b1,4'b0110,4'b0011}, // R4 chain 1 -> 2
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,8'h33,1'b1,4'b0110,4'b0111}, // R1 chained candidate hits
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0001,1'b1,8'h44,1'b0,4'b0110,4'b0110}, // R6 clear
      {1'b0,4'b0000,4'b1000,4'b0000,4'b0000,1'b1,8'h44,1'b0,4'b1110,4'b0110}, // R8 task then hit order
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b0,8'h44,1'b0,4'b1110,4'b0110}, // R1 strobe low
      {1'b0,4'b0000,4'b0000,4'b0000,4'b0000,1'b1,8'h44,1'b1,4'b1110,4'b1110}, // R5 task enabled
      {1'b0,4'b0000,4'b0000,4'b0100,4'b0010,1'b1,8'h22,1'b1,4'b1010,4'b1110}, // R5 R6 dis over chain, hit over clr
      {1'b0,4'b0000,4'b0000,4'b0000,4'b1110,1'b0,8'h00,1'b0,4'b1010,4'b0000}, // R6 bulk clear
      {1'b0,4'b0000,4'b0001,4'b0001,4'b0000,1'b0,8'h00,1'b0,4'b1010,4'b0000}, // R5 dis beats en
      {1'b1,4'b0000,4'b0100,4'b0000,4'b0000,1'b0,8'h00,1'b0,4'b0100,4'b0000}  // R8 write then task
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [NC-1:0] wd, input logic [NC-1:0] ten,
                       input logic [NC-1:0] tdis, input logic [NC-1:0] clr, input logic vld,
                       input logic [DW-1:0] b, input logic [CW-1:0] rxc, input logic [CW-1:0] txc);
      @(negedge clk);
      en_wr = wr; en_wdata = wd; task_en = ten; task_dis = tdis; evt_clr = clr;
      byte_vld = vld; byte_dat = b; rx_count = rxc; tx_count = txc;
      @(posedge clk);
      #1;
      en_wr = 1'b0; task_en = '0; task_dis = '0; evt_clr = '0; byte_vld = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R9 reset state
      chk("R9 match_en", 32'(match_en), 32'h0);
      chk("R9 evt_flag", 32'(evt_flag), 32'h0);
      chk("R9 rx_amount", 32'(rx_amount), 32'h0);
      chk("R9 irq", 32'(irq), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NROW; k++) begin
         logic [34:0] r;
         r = TBL[k];
         step(r[34], r[33:30], r[29:26], r[25:22], r[21:18], r[17], r[16:9],
              CW'(100 + k), CW'(200 + k));
         if (r[8]) begin
            exp_rx = CW'(100 + k);
            exp_tx = CW'(200 + k);
         end
         chk($sformatf("R5/R8 row %0d match_en", k), 32'(match_en), 32'(r[7:4]));
         chk($sformatf("R1/R6 row %0d evt_flag", k), 32'(evt_flag), 32'(r[3:0]));
         chk($sformatf("R2 row %0d rx_amount", k), 32'(rx_amount), 32'(exp_rx));
         chk($sformatf("R2 row %0d tx_amount", k), 32'(tx_amount), 32'(exp_tx));
      end

      // R7 interrupt follows enabled flags
      irq_en = 4'b0010;
      step(1'b1, 4'b0010, '0, '0, '0, 1'b0, 8'h00, 16'd0, 16'd0);
      chk("R7 irq idle", 32'(irq), 32'h0);
      step(1'b0, '0, '0, '0, '0, 1'b1, 8'h22, 16'd50, 16'd60);
      chk("R7 irq raised", 32'(irq), 32'h1);
      chk("R4 chain after irq hit", 32'(match_en), 32'h6);
      @(negedge clk);
      irq_en = 4'b0000;
      #1;
      chk("R7 irq masked", 32'(irq), 32'h0);
      step(1'b0, '0, '0, '0, 4'b0010, 1'b0, 8'h00, 16'd0, 16'd0);
      chk("R6 cleared flag", 32'(evt_flag), 32'h0);

      // R10 duplicate values hit together
      cand_val = {8'h55, 8'h55, 8'h22, 8'h11};
      step(1'b1, 4'b1100, '0, '0, '0, 1'b0, 8'h00, 16'd0, 16'd0);
      step(1'b0, '0, '0, '0, '0, 1'b1, 8'h55, 16'd777, 16'd888);
      chk("R10 both flags", 32'(evt_flag), 32'hC);
      chk("R10 rx_amount", 32'(rx_amount), 32'd777);
      chk("R10 tx_amount", 32'(tx_amount), 32'd888);

      // R4 re-arm beats one-shot, chain wraps from 3 to 0
      oneshot_cfg = 4'b1000; rearm_cfg = 4'b1000; chain_cfg = 4'b1000;
      step(1'b1, 4'b1000, '0, '0, 4'b1111, 1'b0, 8'h00, 16'd0, 16'd0);
      step(1'b0, '0, '0, '0, '0, 1'b1, 8'h55, 16'd5, 16'd6);
      chk("R4 rearm and wrap", 32'(match_en), 32'h9);
      chk("R3 R4 single flag", 32'(evt_flag), 32'h8);

      // R5 disable beats configuration write
      step(1'b1, 4'b1111, '0, 4'b0001, '0, 1'b0, 8'h00, 16'd0, 16'd0);
      chk("R5 dis over write", 32'(match_en), 32'hE);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
   end
endmodule